// File: doc/BRIEF.md
# Configuration Address/Data Access Port

This block gives a host processor access to device configuration space through two small I/O windows. The first is a 32-bit selector word. Software writes it to choose a target: a bus number, a device/function pair and a register dword, plus an enable flag. The second is a four-byte data window. A byte, halfword or word access there turns into one configuration read or write on a downstream request port. That request carries the decoded bus, device/function, byte offset and access length.

There is also a memory-mapped form of access in which no selector word is written first. The target device is chosen by a single set bit among high address lines, and the function and register come from lower address lines. The block converts that address into the same selector word and loads it into the selector register. It then issues the request exactly as a data-window access would.

Only one access is in flight at a time. A request waits on the downstream side until that side accepts it. When the access completes, the processor gets a one-cycle response pulse. A read from an absent device, or a read the block refuses to forward, returns all ones sized to the access length.

Top module: `cfgp_port`

## Requirements
- R1: A 4-byte write of kind 0 (selector access) loads the selector register, and a 4-byte read of kind 0 returns the value last loaded. After reset the selector reads 0.
- R2: A kind-0 access of 1 or 2 bytes leaves the selector register unchanged, and such a read returns all ones sized to the length.
- R3: A kind-1 (data window) access while selector bit 31 is clear issues no downstream request. Kind 3 is never forwarded. A read of either kind returns all ones sized to the length.
- R4: A kind-1 access while selector bits 1:0 are nonzero issues no downstream request, and a read returns all ones sized to the length.
- R5: A forwarded kind-1 access carries these fields: bus = selector[23:16], devfn = selector[15:8], offset = {selector[7:2], cpu_addr[1:0]}, length code, write flag, and write data masked to the length.
- R6: A read that the downstream side marks as hit returns dn_rdata masked to the length, with the upper bytes zero.
- R7: A read that the downstream side marks as a miss returns all ones sized to the length (0xFF, 0xFFFF or 0xFFFFFFFF).
- R8: Downstream handshake and response timing.
  - dn_valid stays high with every request field stable until dn_ready.
  - cpu_ready is low while an access is in progress.
  - cpu_rsp_valid is a single-cycle pulse. It comes one cycle after the accepting edge for unforwarded accesses, and one cycle after the downstream handshake otherwise.
- R9: A kind-2 (mapped) access always forwards a request with bus 0.
  - The device number is the index of the lowest set bit among cpu_addr[21:11], or 11 if none is set.
  - The function is cpu_addr[10:8].
  - The offset is {cpu_addr[7:2], cpu_addr[1:0]}.
- R10: A kind-2 access loads the selector register with {1, 7'b0, 8'h00, devfn, cpu_addr[7:2], 2'b00}, and a later kind-0 read returns that value.
- Size code: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. dn_len is the normalized code (0, 1 or 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor access request |
| cpu_ready | output | 1 | High when a new access can be accepted |
| cpu_kind | input | 2 | 0 selector, 1 data window, 2 mapped, 3 unused |
| cpu_write | input | 1 | 1 for write, 0 for read |
| cpu_size | input | 2 | Access size code |
| cpu_addr | input | 22 | Data-window byte lane [1:0], or full mapped address |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read result, valid with cpu_rsp_valid (zero for writes) |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts and completes the request |
| dn_write | output | 1 | Request is a write |
| dn_bus | output | 8 | Target bus number |
| dn_devfn | output | 8 | Target device (7:3) and function (2:0) |
| dn_offset | output | 8 | Configuration byte offset |
| dn_len | output | 2 | Normalized length code |
| dn_wdata | output | 32 | Write data masked to length |
| dn_rdata | input | 32 | Read data, sampled with dn_ready |
| dn_hit | input | 1 | Target present, sampled with dn_ready |

## Verification
The assertions check the following on every cycle:
- a pending request stays still until it is accepted;
- the response is a single pulse;
- a disabled or misaligned selector never lets a request out;
- a miss returns the sized all-ones value;
- a hit returns the masked data;
- a selector load takes the written value;
- the mapped-address decode points at a set select line.

Some behaviour only the bench scenarios can show, because it needs a reference model that follows software sequences:
- the exact field values sent downstream for each selector and lane;
- lowest-line priority when several select lines are set, and the fallback when none are;
- the write-back of the mapped address into the selector;
- response latency measured against a downstream side that stalls for a varying number of cycles.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int DW = 32;

  typedef enum logic [1:0] {
    KIND_ADDR = 2'd0,
    KIND_DATA = 2'd1,
    KIND_MAP  = 2'd2,
    KIND_NONE = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RESP = 2'd2
  } state_e;

  typedef struct packed {
    logic          wr;
    logic [7:0]    bus;
    logic [7:0]    devfn;
    logic [7:0]    off;
    logic [1:0]    len;
    logic [DW-1:0] wdata;
  } dreq_t;

  // Size codes 2 and 3 both mean a full word.
  function automatic logic [1:0] norm_len(input logic [1:0] sz);
    return sz[1] ? 2'd2 : sz;
  endfunction

  function automatic logic [DW-1:0] len_mask(input logic [1:0] len);
    case (len)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgp_rst_sync.sv
module cfgp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld,
  input  logic [31:0] ld_val,
  output logic [31:0] sel_q,
  output logic        usable
);
  logic [31:0] sel_d;

  always_comb sel_d = ld ? ld_val : sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  // Forwarding needs the enable flag set and a dword-aligned selector.
  assign usable = sel_q[31] && (sel_q[1:0] == 2'b00);

  p_sel_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (sel_q == $past(ld_val)));

  p_sel_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(sel_q));
endmodule

// File: rtl/cfgp_idsel_dec.sv
module cfgp_idsel_dec #(
  parameter int IDSEL_LO = 11,
  parameter int IDSEL_N  = 11,
  parameter int AW       = IDSEL_LO + IDSEL_N
) (
  input  logic [AW-1:0] maddr,
  output logic [31:0]   map_word
);
  localparam logic [4:0] NONE_DEV = 5'(IDSEL_N);

  logic [IDSEL_N-1:0] sel;
  logic [IDSEL_N-1:0] first;
  logic [4:0]         dev;

  assign sel = maddr[IDSEL_LO +: IDSEL_N];

  // Isolate the lowest set select line.
  generate
    for (genvar i = 0; i < IDSEL_N; i++) begin : g_first
      if (i == 0) begin : g_lsb
        assign first[i] = sel[i];
      end else begin : g_upper
        assign first[i] = sel[i] && !(|sel[i-1:0]);
      end
    end
  endgenerate

  always_comb begin
    dev = '0;
    for (int i = 0; i < IDSEL_N; i++) begin
      if (first[i]) dev = dev | 5'(i);
    end
    if (!(|sel)) dev = NONE_DEV;
  end

  always_comb map_word = {1'b1, 7'd0, 8'd0, dev, maddr[10:8], maddr[7:2], 2'b00};

  always_comb begin
    p_idsel_single_r9: assert ($onehot0(first));
    if (|sel) begin
      p_idsel_points_r9: assert (((sel >> dev) & 1) != 0);
    end
  end
endmodule

// File: rtl/cfgp_seq.sv
module cfgp_seq
  import cfgp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  kind_e         cpu_kind,
  input  logic          cpu_write,
  input  logic [1:0]    cpu_size,
  input  logic [1:0]    cpu_lane,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [31:0]   sel_q,
  input  logic          sel_usable,
  input  logic [31:0]   map_word,
  output logic          sel_ld,
  output logic [31:0]   sel_ld_val,
  output logic          cpu_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          dn_valid,
  input  logic          dn_ready,
  output dreq_t         dn_req,
  input  logic [DW-1:0] dn_rdata,
  input  logic          dn_hit
);
  state_e        st_q, st_d;
  dreq_t         req_q, req_new;
  logic          req_ld;
  logic [DW-1:0] rdata_q, rdata_new;
  logic          rdata_ld;
  logic [1:0]    cur_len;
  logic          accept;

  assign cur_len = norm_len(cpu_size);
  assign accept  = (st_q == ST_IDLE) && cpu_valid;

  always_comb begin
    st_d       = st_q;
    req_ld     = 1'b0;
    rdata_ld   = 1'b0;
    sel_ld     = 1'b0;
    sel_ld_val = cpu_wdata;
    req_new    = req_q;
    rdata_new  = rdata_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cpu_valid) begin
          req_ld        = 1'b1;
          rdata_ld      = 1'b1;
          req_new.wr    = cpu_write;
          req_new.len   = cur_len;
          req_new.wdata = cpu_wdata & len_mask(cur_len);
          rdata_new     = cpu_write ? '0 : len_mask(cur_len);
          st_d          = ST_RESP;
          unique case (cpu_kind)
            KIND_ADDR: begin
              if (cpu_size[1]) begin
                if (cpu_write) sel_ld = 1'b1;
                else           rdata_new = sel_q;
              end
            end
            KIND_DATA: begin
              if (sel_usable) begin
                req_new.bus   = sel_q[23:16];
                req_new.devfn = sel_q[15:8];
                req_new.off   = {sel_q[7:2], cpu_lane};
                st_d          = ST_REQ;
              end
            end
            KIND_MAP: begin
              sel_ld        = 1'b1;
              sel_ld_val    = map_word;
              req_new.bus   = map_word[23:16];
              req_new.devfn = map_word[15:8];
              req_new.off   = {map_word[7:2], cpu_lane};
              st_d          = ST_REQ;
            end
            default: ;
          endcase
        end
      end
      ST_REQ: begin
        if (dn_ready) begin
          rdata_ld  = 1'b1;
          rdata_new = req_q.wr ? '0 :
                      (dn_hit ? (dn_rdata & len_mask(req_q.len)) : len_mask(req_q.len));
          st_d      = ST_RESP;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (req_ld) req_q <= req_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_ld) rdata_q <= rdata_new;
  end

  assign cpu_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_rdata = rdata_q;
  assign dn_valid  = (st_q == ST_REQ);
  assign dn_req    = req_q;

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_req)));

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && cpu_ready));

  p_gate_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_kind == KIND_DATA && !sel_q[31]) |=> !dn_valid);

  p_gate_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_kind == KIND_DATA && sel_q[1:0] != 2'b00) |=> !dn_valid);

  p_miss_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready && !dn_req.wr && !dn_hit)
      |=> (rsp_rdata == len_mask($past(dn_req.len))));

  p_hit_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready && !dn_req.wr && dn_hit)
      |=> (rsp_rdata == ($past(dn_rdata) & len_mask($past(dn_req.len)))));
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
  import cfgp_pkg::*;
#(
  parameter int IDSEL_LO = 11,
  parameter int IDSEL_N  = 11,
  parameter int AW       = IDSEL_LO + IDSEL_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  output logic          cpu_ready,
  input  logic [1:0]    cpu_kind,
  input  logic          cpu_write,
  input  logic [1:0]    cpu_size,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic          cpu_rsp_valid,
  output logic [31:0]   cpu_rdata,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic          dn_write,
  output logic [7:0]    dn_bus,
  output logic [7:0]    dn_devfn,
  output logic [7:0]    dn_offset,
  output logic [1:0]    dn_len,
  output logic [31:0]   dn_wdata,
  input  logic [31:0]   dn_rdata,
  input  logic          dn_hit
);
  logic        rst_n_s;
  logic        sel_ld;
  logic [31:0] sel_ld_val;
  logic [31:0] sel_q;
  logic        sel_usable;
  logic [31:0] map_word;
  dreq_t       dn_req;

  cfgp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cfgp_addr_reg u_sel (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ld     (sel_ld),
    .ld_val (sel_ld_val),
    .sel_q  (sel_q),
    .usable (sel_usable)
  );

  cfgp_idsel_dec #(
    .IDSEL_LO (IDSEL_LO),
    .IDSEL_N  (IDSEL_N),
    .AW       (AW)
  ) u_dec (
    .maddr    (cpu_addr),
    .map_word (map_word)
  );

  cfgp_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cpu_valid  (cpu_valid),
    .cpu_kind   (kind_e'(cpu_kind)),
    .cpu_write  (cpu_write),
    .cpu_size   (cpu_size),
    .cpu_lane   (cpu_addr[1:0]),
    .cpu_wdata  (cpu_wdata),
    .sel_q      (sel_q),
    .sel_usable (sel_usable),
    .map_word   (map_word),
    .sel_ld     (sel_ld),
    .sel_ld_val (sel_ld_val),
    .cpu_ready  (cpu_ready),
    .rsp_valid  (cpu_rsp_valid),
    .rsp_rdata  (cpu_rdata),
    .dn_valid   (dn_valid),
    .dn_ready   (dn_ready),
    .dn_req     (dn_req),
    .dn_rdata   (dn_rdata),
    .dn_hit     (dn_hit)
  );

  assign dn_write  = dn_req.wr;
  assign dn_bus    = dn_req.bus;
  assign dn_devfn  = dn_req.devfn;
  assign dn_offset = dn_req.off;
  assign dn_len    = dn_req.len;
  assign dn_wdata  = dn_req.wdata;
endmodule

// File: tb/cfgp_port_test.sv
`timescale 1ns/1ps
module cfgp_port_test;

  typedef struct packed {
    logic [1:0]  kind;
    logic        wr;
    logic [1:0]  size;
    logic [21:0] addr;
    logic [31:0] wdata;
    logic [3:0]  dly;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, 2'd2, 22'h000000, 32'h8000_1208, 4'd0},
    '{2'd0, 1'b0, 2'd2, 22'h000000, 32'h0,         4'd0},
    '{2'd1, 1'b0, 2'd0, 22'h000001, 32'h0,         4'd2},
    '{2'd1, 1'b0, 2'd1, 22'h000002, 32'h0,         4'd0},
    '{2'd1, 1'b0, 2'd2, 22'h000000, 32'h0,         4'd3},
    '{2'd1, 1'b1, 2'd1, 22'h000000, 32'hDEAD_BEEF, 4'd1},
    '{2'd0, 1'b1, 2'd3, 22'h000000, 32'h8005_1A40, 4'd0},
    '{2'd1, 1'b0, 2'd1, 22'h000002, 32'h0,         4'd0},
    '{2'd0, 1'b1, 2'd2, 22'h000000, 32'h0000_1208, 4'd0},
    '{2'd1, 1'b0, 2'd2, 22'h000000, 32'h0,         4'd0},
    '{2'd1, 1'b1, 2'd0, 22'h000003, 32'h0000_0011, 4'd0},
    '{2'd0, 1'b1, 2'd2, 22'h000000, 32'h8000_120A, 4'd0},
    '{2'd1, 1'b0, 2'd0, 22'h000000, 32'h0,         4'd0},
    '{2'd0, 1'b1, 2'd1, 22'h000000, 32'h1234_5678, 4'd0},
    '{2'd0, 1'b0, 2'd0, 22'h000000, 32'h0,         4'd0},
    '{2'd0, 1'b0, 2'd2, 22'h000000, 32'h0,         4'd0},
    '{2'd2, 1'b0, 2'd2, 22'h012324, 32'h0,         4'd1},
    '{2'd0, 1'b0, 2'd2, 22'h000000, 32'h0,         4'd0},
    '{2'd2, 1'b0, 2'd0, 22'h000105, 32'h0,         4'd0},
    '{2'd2, 1'b1, 2'd2, 22'h000810, 32'hCAFE_F00D, 4'd4},
    '{2'd2, 1'b0, 2'd1, 22'h004002, 32'h0,         4'd0},
    '{2'd3, 1'b0, 2'd2, 22'h000000, 32'h0,         4'd0},
    '{2'd0, 1'b0, 2'd2, 22'h000000, 32'h0,         4'd0}
  };

  logic        clk;
  logic        rst_n;
  logic        cpu_valid;
  logic        cpu_ready;
  logic [1:0]  cpu_kind;
  logic        cpu_write;
  logic [1:0]  cpu_size;
  logic [21:0] cpu_addr;
  logic [31:0] cpu_wdata;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rdata;
  logic        dn_valid;
  logic        dn_ready;
  logic        dn_write;
  logic [7:0]  dn_bus;
  logic [7:0]  dn_devfn;
  logic [7:0]  dn_offset;
  logic [1:0]  dn_len;
  logic [31:0] dn_wdata;
  logic [31:0] dn_rdata;
  logic        dn_hit;

  int nchecks = 0;
  int nfail   = 0;
  int cur_dly = 0;
  int rcnt    = 0;
  logic [31:0] m_sel;
  logic        last_map;

  cfgp_port uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_valid     (cpu_valid),
    .cpu_ready     (cpu_ready),
    .cpu_kind      (cpu_kind),
    .cpu_write     (cpu_write),
    .cpu_size      (cpu_size),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rdata     (cpu_rdata),
    .dn_valid      (dn_valid),
    .dn_ready      (dn_ready),
    .dn_write      (dn_write),
    .dn_bus        (dn_bus),
    .dn_devfn      (dn_devfn),
    .dn_offset     (dn_offset),
    .dn_len        (dn_len),
    .dn_wdata      (dn_wdata),
    .dn_rdata      (dn_rdata),
    .dn_hit        (dn_hit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Downstream model: device 3 and every nonzero bus are absent.
  assign dn_hit   = (dn_bus == 8'd0) && (dn_devfn[7:3] != 5'd3);
  assign dn_rdata = {dn_offset, dn_devfn, 8'h5A, 8'hC3};

  always @(negedge clk) begin
    if (dn_ready) begin
      dn_ready = 1'b0;
      rcnt     = 0;
    end else if (dn_valid) begin
      if (rcnt >= cur_dly) dn_ready = 1'b1;
      else                 rcnt = rcnt + 1;
    end
  end

  function automatic logic [31:0] ones(input logic [1:0] sz);
    if (sz[1])      return 32'hFFFF_FFFF;
    else if (sz[0]) return 32'h0000_FFFF;
    else            return 32'h0000_00FF;
  endfunction

  function automatic logic [4:0] ref_dev(input logic [21:0] a);
    logic [4:0] d;
    logic found;
    d = 5'd11;
    found = 1'b0;
    for (int i = 0; i < 11; i++) begin
      if (!found && a[11+i]) begin
        d = 5'(i);
        found = 1'b1;
      end
    end
    return d;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] k, input logic w, input logic [1:0] sz,
                     input logic [21:0] a, input logic [31:0] wd, input int d);
    logic        seen;
    logic        hold_bad;
    logic [26:0] cap;
    logic [31:0] cap_wd;
    logic [31:0] got;
    int          cycles;
    logic        exp_req;
    logic [26:0] exp_cap;
    logic [31:0] exp_wd;
    logic [31:0] rexp;
    string       tag;
    string       rtag;
    logic [7:0]  e_bus, e_devfn, e_off;
    logic [1:0]  e_len;

    // Reference model
    exp_req = 1'b0;
    e_len   = sz[1] ? 2'd2 : sz;
    rexp    = ones(sz);
    tag     = "R5";
    rtag    = "R5";
    e_bus   = 8'd0;
    e_devfn = 8'd0;
    e_off   = 8'd0;
    case (k)
      2'd0: begin
        if (sz[1]) begin
          if (w) m_sel = wd;
          else   rexp  = m_sel;
          tag  = last_map ? "R10" : "R1";
        end else begin
          tag  = "R2";
        end
        rtag = tag;
        last_map = 1'b0;
      end
      2'd1: begin
        if (m_sel[31] && m_sel[1:0] == 2'b00) begin
          exp_req = 1'b1;
          tag = "R5";
        end else begin
          tag = m_sel[31] ? "R4" : "R3";
        end
        rtag = tag;
        last_map = 1'b0;
      end
      2'd2: begin
        m_sel    = {1'b1, 7'd0, 8'd0, ref_dev(a), a[10:8], a[7:2], 2'b00};
        exp_req  = 1'b1;
        tag      = "R9";
        last_map = 1'b1;
      end
      default: begin
        tag  = "R3";
        rtag = tag;
        last_map = 1'b0;
      end
    endcase
    if (exp_req) begin
      e_bus   = m_sel[23:16];
      e_devfn = m_sel[15:8];
      e_off   = {m_sel[7:2], a[1:0]};
      if ((e_bus == 8'd0) && (e_devfn[7:3] != 5'd3)) begin
        rexp = {e_off, e_devfn, 8'h5A, 8'hC3} & ones(sz);
        rtag = "R6";
      end else begin
        rexp = ones(sz);
        rtag = "R7";
      end
    end
    exp_cap = {e_bus, e_devfn, e_off, e_len, w};
    exp_wd  = wd & ones(sz);

    // Drive the access
    cur_dly = d;
    @(negedge clk);
    cpu_valid = 1'b1;
    cpu_kind  = k;
    cpu_write = w;
    cpu_size  = sz;
    cpu_addr  = a;
    cpu_wdata = wd;
    @(negedge clk);
    cpu_valid = 1'b0;
    cycles   = 1;
    seen     = 1'b0;
    hold_bad = 1'b0;
    cap      = '0;
    cap_wd   = '0;
    while (!cpu_rsp_valid && cycles < 60) begin
      if (dn_valid) begin
        if (!seen) begin
          seen   = 1'b1;
          cap    = {dn_bus, dn_devfn, dn_offset, dn_len, dn_write};
          cap_wd = dn_wdata;
        end else if ({dn_bus, dn_devfn, dn_offset, dn_len, dn_write} != cap ||
                     dn_wdata != cap_wd) begin
          hold_bad = 1'b1;
        end
        if (cpu_ready) hold_bad = 1'b1;
      end
      @(negedge clk);
      cycles++;
    end
    got = cpu_rdata;

    chk(tag, 32'(seen), 32'(exp_req), "request issued");
    if (seen && exp_req) begin
      chk(tag, 32'(cap), 32'(exp_cap), "request fields");
      chk(tag, cap_wd, exp_wd, "request write data");
      chk("R8", 32'(hold_bad), 32'd0, "request held stable while busy");
    end
    chk("R8", 32'(cycles), exp_req ? 32'(2 + d) : 32'd1, "response latency");
    if (!w) chk(rtag, got, rexp, "read data");
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    cpu_valid = 1'b0;
    cpu_kind  = 2'd0;
    cpu_write = 1'b0;
    cpu_size  = 2'd0;
    cpu_addr  = '0;
    cpu_wdata = '0;
    dn_ready  = 1'b0;
    m_sel     = '0;
    last_map  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk("R8", 32'(cpu_ready), 32'd1, "ready after reset");
    chk("R8", 32'(dn_valid), 32'd0, "no request after reset");
    chk("R8", 32'(cpu_rsp_valid), 32'd0, "no response after reset");
    run(2'd0, 1'b0, 2'd2, 22'h0, 32'h0, 0);   // R1: selector reads 0

    // Vector table
    for (int i = 0; i < NV; i++) begin
      run(VEC[i].kind, VEC[i].wr, VEC[i].size, VEC[i].addr, VEC[i].wdata, int'(VEC[i].dly));
    end

    // Directed: several select lines set, lowest wins (R9)
    run(2'd2, 1'b0, 2'd2, 22'h3F0004, 32'h0, 2);
    run(2'd0, 1'b0, 2'd2, 22'h0, 32'h0, 0);

    // Directed: highest select line alone (R9)
    run(2'd2, 1'b0, 2'd0, 22'h200007, 32'h0, 0);

    // Directed: reset clears the selector (R1)
    run(2'd0, 1'b1, 2'd2, 22'h0, 32'h8000_ABCC, 0);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_sel    = '0;
    last_map = 1'b0;
    run(2'd0, 1'b0, 2'd2, 22'h0, 32'h0, 0);
    run(2'd1, 1'b0, 2'd2, 22'h0, 32'h0, 0);   // R3 after reset: disabled

    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end

endmodule